// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Access

This block is a register-mapped SPI master that carries out one full-duplex 8-bit exchange each time software writes its transmit register. A simple 32-bit register bus sets the serial clock rate and the SPI mode, enables the master, starts exchanges and collects received bytes. On the serial side the block drives a clock, a data-out line and one active-low chip select, and it samples a data-in line.

The serial clock comes from two dividers in series. The first is a prescaler that divides the input clock by one of two parameter values, 16 or 128 by default. The second divides by (N+1)*2, where N is a 5-bit field. The mode bits and the divider settings share one control byte, and the block copies that byte when an exchange starts. Software polls a busy flag before it writes the next byte. It polls a receive-full flag before it reads the received byte.

Top module: `spi_reg_master`

## Requirements
- R1: The control byte is at offset 0x00 and reads back as written in bits 7:0, with the upper bits reading zero. The enable bit is bit 0 at offset 0x08. Reads of offsets 0x0C and 0x14, and of any unmapped offset, return zero.
- R2: Let P be PRE_LO when control bit 5 is 0 and PRE_HI when it is 1, and let N be control bits 4:0. During an exchange, each SCLK half-period lasts P*(N+1) input clock cycles.
- R3: Control bit 6 sets the SCLK idle level. While the chip select is high, SCLK equals the current value of bit 6.
- R4: Control bit 7 selects the clock phase. When it is 0, MISO is sampled on leading edges and MOSI changes on trailing edges. When it is 1, MOSI changes on every leading edge except the first, and MISO is sampled on trailing edges.
- R5: A write to offset 0x0C while the block is enabled and idle starts an exchange of write-data bits 7:0, sent MSB first. The upper write-data bits are ignored.
- R6: The chip select goes low on the clock edge that accepts the write. SCLK then makes 16 edges, one every half-period, and the chip select returns high one half-period after the last edge.
- R7: Status bit 0 at offset 0x04 reads 1 exactly while the chip select is low. A write to offset 0x0C during that time is ignored.
- R8: While the enable bit is 0, a write to offset 0x0C starts nothing and leaves the status at zero.
- R9: When an exchange ends, the received byte is readable at offset 0x10 in bits 7:0, with the upper bits reading zero, and status bit 2 is set. A later exchange overwrites the byte even if the earlier one was never read.
- R10: A read of offset 0x10 clears status bit 2. A write to offset 0x04 with bit 2 clear also clears it.
- R11: After reset, every register reads zero, the chip select is high and SCLK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Byte address of the register access |
| regWe | input | 1 | Write strobe, one cycle per write |
| regWdata | input | 32 | Write data |
| regRe | input | 1 | Read strobe; read data is valid in the same cycle |
| regRdata | output | 32 | Read data |
| spiMiso | input | 1 | Serial data in |
| spiSclk | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiCsN | output | 1 | Active-low chip select |

## Verification
The bench builds the block with PRE_LO=2 and PRE_HI=4 and keeps the default frame width of 8 and divider width of 5. With these values even the slowest setting (N=31 with the upper prescaler) finishes an exchange in about 2200 cycles. That lets the bench run all four clock modes and both prescaler selections, and compare every SCLK edge, MOSI bit and chip-select interval against a behavioural model. A busy write, a disabled write and an unread overwrite are each covered by a directed sequence.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Byte offsets of the register words
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_STAT = 'h04;
  localparam int OFS_SYS  = 'h08;
  localparam int OFS_TX   = 'h0C;
  localparam int OFS_RX   = 'h10;

  // Status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_RXF  = 2;

  // Strobes from the sequencer to the shifting datapath
  typedef struct packed {
    logic start;   // load the transmit byte, begin the frame
    logic toggle;  // an SCLK edge happens now
    logic sample;  // capture MISO
    logic launch;  // move MOSI to the next bit
    logic finish;  // frame done, move the received byte to the buffer
  } seqStrobe_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 5,
  parameter int PRE_LO  = 16,
  parameter int PRE_HI  = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWe,
  input  logic [DATA_W-1:0]  regWdata,
  input  logic               regRe,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [FRAME_W-1:0] rxByte,
  output seqStrobe_t         strb,
  output logic               active,
  output logic [DIV_W+2:0]   ctrlByte,
  output logic               enable,
  output logic               rxFull,
  output logic [FRAME_W-1:0] txByte
);

  localparam int CTRL_W    = DIV_W + 3;
  localparam int PRE_BIT   = DIV_W;
  localparam int CPHA_BIT  = DIV_W + 2;
  localparam int LAST_EDGE = 2 * FRAME_W;
  localparam int END_EDGE  = 2 * FRAME_W + 1;
  localparam int EDGE_W    = $clog2(END_EDGE + 1);
  localparam int CNT_W     = $clog2(PRE_HI * (2 ** DIV_W) + 1);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_SYS  = ADDR_W'(OFS_SYS);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(OFS_TX);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(OFS_RX);

  logic [CTRL_W-1:0] ctrlReg, cfgReg;
  logic              enReg;
  logic [CNT_W-1:0]  halfCnt, halfM1, preVal, divPlus;
  logic [EDGE_W-1:0] edgeNum, nextEdge;
  logic              tick, leading, cfgCpha, txWrite, rxRead, statWrite;
  logic              unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:CTRL_W];

  assign txWrite   = regWe && (regAddr == A_TX);
  assign rxRead    = regRe && (regAddr == A_RX);
  assign statWrite = regWe && (regAddr == A_STAT);

  // Half-period length from the copied control byte
  always_comb begin
    preVal  = cfgReg[PRE_BIT] ? CNT_W'(PRE_HI) : CNT_W'(PRE_LO);
    divPlus = CNT_W'(cfgReg[DIV_W-1:0]) + CNT_W'(1);
    halfM1  = preVal * divPlus - CNT_W'(1);
  end

  assign cfgCpha  = cfgReg[CPHA_BIT];
  assign tick     = active && (halfCnt == halfM1);
  assign nextEdge = edgeNum + EDGE_W'(1);
  assign leading  = nextEdge[0];

  always_comb begin
    strb        = '0;
    strb.start  = txWrite && enReg && !active;
    strb.toggle = tick && (nextEdge <= EDGE_W'(LAST_EDGE));
    strb.finish = tick && (nextEdge == EDGE_W'(END_EDGE));
    strb.sample = strb.toggle && (cfgCpha ? !leading : leading);
    strb.launch = strb.toggle &&
                  (cfgCpha ? (leading && (nextEdge != EDGE_W'(1))) : !leading);
  end

  // Frame sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      halfCnt <= '0;
      edgeNum <= '0;
      cfgReg  <= '0;
    end else if (strb.start) begin
      active  <= 1'b1;
      halfCnt <= '0;
      edgeNum <= '0;
      cfgReg  <= ctrlReg;
    end else if (active) begin
      if (tick) begin
        halfCnt <= '0;
        edgeNum <= nextEdge;
        if (strb.finish) active <= 1'b0;
      end else begin
        halfCnt <= halfCnt + CNT_W'(1);
      end
    end
  end

  // Software-visible registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      enReg   <= 1'b0;
      rxFull  <= 1'b0;
    end else begin
      if (regWe && (regAddr == A_CTRL)) ctrlReg <= regWdata[CTRL_W-1:0];
      if (regWe && (regAddr == A_SYS))  enReg   <= regWdata[0];
      if (strb.finish)                          rxFull <= 1'b1;
      else if (rxRead)                          rxFull <= 1'b0;
      else if (statWrite && !regWdata[ST_RXF])  rxFull <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL: regRdata[CTRL_W-1:0] = ctrlReg;
      A_STAT: begin
        regRdata[ST_BUSY] = active;
        regRdata[ST_RXF]  = rxFull;
      end
      A_SYS:  regRdata[0] = enReg;
      A_RX:   regRdata[FRAME_W-1:0] = rxByte;
      default: regRdata = '0;
    endcase
  end

  assign ctrlByte = ctrlReg;
  assign enable   = enReg;
  assign txByte   = regWdata[FRAME_W-1:0];

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int FRAME_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic               active,
  input  logic               idleCpol,
  input  logic [FRAME_W-1:0] txByte,
  input  logic               spiMiso,
  output logic               spiSclk,
  output logic               spiMosi,
  output logic               spiCsN,
  output logic [FRAME_W-1:0] rxByte
);

  logic [FRAME_W-1:0] txSh, rxSh, rxBuf;
  logic               sclkInt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh    <= '0;
      rxSh    <= '0;
      rxBuf   <= '0;
      sclkInt <= 1'b0;
    end else begin
      if (strb.start) begin
        txSh    <= txByte;
        sclkInt <= idleCpol;
      end else begin
        if (strb.toggle) sclkInt <= ~sclkInt;
        if (strb.launch) txSh <= {txSh[FRAME_W-2:0], 1'b0};
        if (strb.sample) rxSh <= {rxSh[FRAME_W-2:0], spiMiso};
      end
      if (strb.finish) rxBuf <= rxSh;
    end
  end

  assign spiSclk = active ? sclkInt : idleCpol;
  assign spiMosi = txSh[FRAME_W-1];
  assign spiCsN  = ~active;
  assign rxByte  = rxBuf;

endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 32,
  parameter int FRAME_W = 8,
  parameter int DIV_W   = 5,
  parameter int PRE_LO  = 16,
  parameter int PRE_HI  = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              regRe,
  output logic [DATA_W-1:0] regRdata,
  input  logic              spiMiso,
  output logic              spiSclk,
  output logic              spiMosi,
  output logic              spiCsN
);

  localparam int CTRL_W = DIV_W + 3;

  seqStrobe_t         strb;
  logic               active, enable, rxFull;
  logic [CTRL_W-1:0]  ctrlByte;
  logic [FRAME_W-1:0] txByte, rxByte;

  spi_reg_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAME_W(FRAME_W),
    .DIV_W(DIV_W), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRe(regRe), .regRdata(regRdata),
    .rxByte(rxByte), .strb(strb), .active(active), .ctrlByte(ctrlByte),
    .enable(enable), .rxFull(rxFull), .txByte(txByte)
  );

  spi_reg_dp #(.FRAME_W(FRAME_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .active(active),
    .idleCpol(ctrlByte[CTRL_W-2]), .txByte(txByte), .spiMiso(spiMiso),
    .spiSclk(spiSclk), .spiMosi(spiMosi), .spiCsN(spiCsN), .rxByte(rxByte)
  );

endmodule

// File: rtl/spi_reg_master_chk.sv
module spi_reg_master_chk
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CTRL_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic              regRe,
  input logic              spiCsN,
  input logic              spiSclk,
  input logic [CTRL_W-1:0] ctrlByte,
  input logic              enable,
  input logic              rxFull
);

  localparam logic [ADDR_W-1:0] A_TX = ADDR_W'(OFS_TX);
  localparam logic [ADDR_W-1:0] A_RX = ADDR_W'(OFS_RX);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> (spiSclk == ctrlByte[CTRL_W-2])); // R3

  AST_TX_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_TX && enable && spiCsN) |=> !spiCsN); // R5

  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_TX && !enable && spiCsN) |=> spiCsN); // R8

  AST_END_SETS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiCsN) |-> rxFull); // R9

  AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (regRe && regAddr == A_RX && spiCsN) |=> !rxFull); // R10

endmodule

bind spi_reg_master spi_reg_master_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regRe(regRe),
  .spiCsN(spiCsN), .spiSclk(spiSclk), .ctrlByte(ctrlByte),
  .enable(enable), .rxFull(rxFull)
);

// File: tb/spi_reg_master_tb.sv
`timescale 1ns/1ps
module spi_reg_master_tb;

  localparam int PLO = 2;
  localparam int PHI = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic        regRe = 1'b0;
  logic [31:0] regRdata;
  logic        spiMiso = 1'b0;
  logic        spiSclk, spiMosi, spiCsN;

  always #2.5 clk = ~clk;

  spi_reg_master #(.PRE_LO(PLO), .PRE_HI(PHI)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRe(regRe), .regRdata(regRdata),
    .spiMiso(spiMiso), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiCsN(spiCsN)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  // Behavioural model state
  bit         mActive = 0;
  bit         mEn = 0;
  int         mStart = 0;
  int         mH = 1;
  logic [7:0] mCtrl = '0, mCfg = '0, mTx = '0, mSlave = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int halfOf(input logic [7:0] c);
    return (c[5] ? PHI : PLO) * (int'(c[4:0]) + 1);
  endfunction

  function automatic int bitIdx(input int tog, input bit cpha);
    int lead;
    if (!cpha) return 7 - tog / 2;
    lead = (tog + 1) / 2;
    return 7 - ((lead > 0) ? lead - 1 : 0);
  endfunction

  // Per-clock comparison against the model; also plays the slave on MISO
  always begin
    int d, tog, idx;
    @(posedge clk);
    cyc++;
    #1;
    if (rstN) begin
      d = cyc - mStart;
      if (mActive && d >= 0 && d < 17 * mH) begin
        tog = d / mH;
        if (tog > 16) tog = 16;
        check("R6 cs low during frame", {31'd0, spiCsN}, 32'd0);
        check("R2 sclk edge timing", {31'd0, spiSclk}, {31'd0, mCfg[6] ^ tog[0]});
        idx = bitIdx(tog, mCfg[7]);
        if (idx >= 0) begin
          check("R4 mosi bit", {31'd0, spiMosi}, {31'd0, mTx[idx]});
          spiMiso = mSlave[idx];
        end
      end else begin
        if (mActive && d >= 17 * mH) mActive = 0;
        check("R6 cs high when idle", {31'd0, spiCsN}, 32'd1);
        check("R3 sclk idle level", {31'd0, spiSclk}, {31'd0, mCtrl[6]});
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] v);
    @(negedge clk);
    regAddr = a; regWdata = v; regWe = 1'b1;
    case (a)
      5'h00: mCtrl = v[7:0];
      5'h08: mEn = v[0];
      5'h0C: if (mEn && !(mActive && (cyc + 1 - mStart) <= 17 * mH)) begin
               mActive = 1; mStart = cyc + 1; mTx = v[7:0];
               mCfg = mCtrl; mH = halfOf(mCtrl);
             end
      default: ;
    endcase
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a; regRe = 1'b1;
    #1 v = regRdata;
    @(negedge clk);
    regRe = 1'b0;
  endtask

  task automatic waitIdle(output logic [31:0] s);
    s = 32'd1;
    for (int i = 0; i < 5000 && s[0]; i++) rd(5'h04, s);
  endtask

  task automatic xfer(input logic [7:0] ctl, input logic [31:0] tx, input logic [7:0] slave);
    logic [31:0] v;
    wr(5'h00, {24'd0, ctl});
    mSlave = slave;
    wr(5'h0C, tx);
    rd(5'h04, v);
    check("R7 busy during frame", v, 32'h1);
    waitIdle(v);
    check("R9 status after frame", v, 32'h4);
    rd(5'h10, v);
    check("R9 received byte", v, {24'd0, slave});
    rd(5'h04, v);
    check("R10 read clears full", v, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all R) actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    check("R11 cs after reset", {31'd0, spiCsN}, 32'd1);
    check("R11 sclk after reset", {31'd0, spiSclk}, 32'd0);
    rd(5'h00, v); check("R11 ctrl reset", v, 0);
    rd(5'h04, v); check("R11 status reset", v, 0);
    rd(5'h08, v); check("R11 enable reset", v, 0);
    rd(5'h10, v); check("R11 rx reset", v, 0);

    // R8 disabled write starts nothing
    wr(5'h0C, 32'h55);
    repeat (10) @(negedge clk);
    rd(5'h04, v); check("R8 status while disabled", v, 0);

    // R1 register map
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); check("R1 ctrl readback", v, 32'hFF);
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, v); check("R1 enable readback", v, 32'h1);
    rd(5'h0C, v); check("R1 tx reads zero", v, 0);
    rd(5'h14, v); check("R1 offset 0x14 reads zero", v, 0);
    wr(5'h00, 32'h0);

    // Four modes, both prescalers, several dividers (R2 R3 R4 R5)
    xfer(8'h00, 32'hA5, 8'h3C);
    xfer(8'h83, 32'h5A, 8'hC3);
    xfer(8'h62, 32'h96, 8'h69);
    xfer(8'hFF, 32'h01, 8'h80);
    xfer(8'h21, 32'hFE, 8'h7F);

    // R5 upper write bits ignored
    xfer(8'h00, 32'hABCD_EF12, 8'hF0);

    // R7 write while busy is ignored
    wr(5'h00, 32'h01);
    mSlave = 8'h22;
    wr(5'h0C, 32'h11);
    repeat (3) @(negedge clk);
    wr(5'h0C, 32'h77);
    waitIdle(v);
    repeat (20) @(negedge clk);
    rd(5'h04, v); check("R7 no second frame", v, 32'h4);
    rd(5'h10, v); check("R7 first byte kept", v, 32'h22);

    // R9 overwrite without read
    mSlave = 8'h44; wr(5'h0C, 32'h33); waitIdle(v);
    mSlave = 8'h66; wr(5'h0C, 32'h55); waitIdle(v);
    check("R9 full after second frame", v, 32'h4);
    rd(5'h10, v); check("R9 overwritten byte", v, 32'h66);

    // R10 status write with bit 2 clear
    mSlave = 8'h99; wr(5'h0C, 32'h12); waitIdle(v);
    check("R10 full before clear", v, 32'h4);
    wr(5'h04, 32'h0);
    rd(5'h04, v); check("R10 status write clears", v, 0);
    rd(5'h10, v); check("R10 byte still readable", v, 32'h99);

    // R8 disable again
    wr(5'h08, 32'h0);
    wr(5'h0C, 32'hC3);
    repeat (10) @(negedge clk);
    rd(5'h04, v); check("R8 no start after disable", v, 0);

    repeat (5) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule